// File: doc/BRIEF.md
# Dual Gated Mode-Selectable Timer

This block holds two up-counting timers, Timer 0 and Timer 1. Each one is built from a low byte and a high byte. A single 8-bit configuration register gives each timer a 2-bit counting mode and a gate-enable bit. Both timers advance only on cycles where the prescaled clock-enable input `tick` is high and the timer's run condition holds. The run condition is the timer's run-enable bit, and, when the gate bit is set, also the synchronised active-low external gate input.

Four counting modes are available:
- a 13-bit counter (5-bit prescale field plus high byte),
- a 16-bit counter,
- an 8-bit counter with auto-reload from the high byte,
- a split mode.

In split mode, Timer 0 becomes two independent 8-bit timers and Timer 1 is frozen. Each timer owns one sticky overflow flag, presented on `ovf_flag` for an interrupt controller. Software clears a flag through the register port.

The register port is a plain single-cycle port: a write is taken on any clock edge where `bus_we` is high, and `bus_rdata` shows the register selected by `bus_addr` combinationally. It never stalls, so it carries no valid/ready handshake. Back-pressure does not arise.

Top module: `dual_timer`

## Requirements
- R1: After reset, the configuration register, all four count bytes and both overflow flags are 0.
- R2: Register addresses are: 0 config, 1 Timer 0 low, 2 Timer 0 high, 3 Timer 1 low, 4 Timer 1 high, 5 flags (bit 0 Timer 0, bit 1 Timer 1). Config layout is bit 7 Timer 1 gate enable, bits 5:4 Timer 1 mode, bit 3 Timer 0 gate enable, bits 1:0 Timer 0 mode. Config bits 6 and 2 always read 0, and writing 1 to them has no effect.
- R3: Mode 00 counts 13 bits: low-byte bits 4:0 carry into the high byte. Low-byte bits 7:5 are unchanged. It wraps from high byte 0xFF with low bits 0x1F.
- R4: Mode 01 counts the 16-bit value {high, low} and wraps from 0xFFFF to 0x0000.
- R5: Mode 10 increments the low byte only. When the low byte is 0xFF, the next step loads it from the high byte, which is itself never changed by counting.
- R6: Timer 0 mode 11 splits Timer 0 into two independent 8-bit counters:
  - the low byte uses Timer 0's run condition and sets flag 0 on wrap;
  - the high byte runs when `run_en[1]` is 1 (no gate) and sets flag 1 on wrap.
- R7: Timer 1 mode 11 holds both Timer 1 bytes unchanged, and Timer 1 sets no flag.
- R8: A timer steps once per cycle with `tick` high and its run condition true. The run condition is `run_en[i]` when the gate enable is 0, and `run_en[i]` AND a low synchronised `gate_n[i]` when the gate enable is 1. Without both, the count holds.
- R9: A flag sets on the edge where its counter wraps to zero and then stays set. Writing 0 to its bit at address 5 clears it, and writing 1 has no effect.
- R10: A register write to a count byte takes priority over a step in the same cycle. The written value is stored, and that timer does not step in that cycle.
- R11: A `gate_n` level sampled at rising edge k governs counting at edge k+2 (two-flop synchroniser).
- R12: While Timer 0 is split, Timer 1 keeps counting in its own mode but its wraps do not set flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| run_en | input | 2 | Run-enable bits, bit i for Timer i |
| gate_n | input | 2 | Asynchronous active-low external gates |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| ovf_flag | output | 2 | Sticky overflow flags, bit i for Timer i |

## Verification
The bound checker watches, on every cycle:
- that the reserved config bits read 0;
- that counts hold when there is no tick and no write;
- that Timer 1 is frozen in mode 11;
- that the reload source byte never counts;
- that flags stay set until cleared;
- that a written low byte carries the written value.

The exact mode arithmetic needs the bench's directed scenarios, with chosen starting counts:
- the 13-bit carry out of bit 4;
- the 16-bit wrap;
- the reload value;
- which counter feeds which flag in split mode;
- the two-edge gate latency.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int ADDR_W = 3;
  localparam int N_TMR  = 2;

  typedef enum logic [1:0] {
    MODE_13     = 2'b00,
    MODE_16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmode_e;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_T0L  = 3'd1;
  localparam logic [ADDR_W-1:0] A_T0H  = 3'd2;
  localparam logic [ADDR_W-1:0] A_T1L  = 3'd3;
  localparam logic [ADDR_W-1:0] A_T1H  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd5;

  localparam logic [BYTE_W-1:0] CFG_MASK = 8'hBB;
endpackage

// File: rtl/dtmr_gate_sync.sv
module dtmr_gate_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_n,
  output logic [N-1:0] sync_n
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], async_n[g]};
    end
    assign sync_n[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
  import dtmr_pkg::*;
#(
  parameter bit CAN_SPLIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode,
  input  logic              step_lo,
  input  logic              step_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              wrap_lo,
  output logic              wrap_hi
);
  logic [BYTE_W-1:0] lo_n, hi_n;
  logic              blk;

  always_comb begin
    lo_n    = lo_q;
    hi_n    = hi_q;
    wrap_lo = 1'b0;
    wrap_hi = 1'b0;
    blk     = wr_lo | wr_hi;
    case (mode)
      MODE_13: begin
        if (step_lo && !blk) begin
          if (&lo_q[PRE_W-1:0]) begin
            lo_n[PRE_W-1:0] = '0;
            hi_n            = hi_q + 1'b1;
            wrap_lo         = &hi_q;
          end else begin
            lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
          end
        end
      end
      MODE_16: begin
        if (step_lo && !blk) begin
          {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
          wrap_lo      = &{hi_q, lo_q};
        end
      end
      MODE_RELOAD: begin
        if (step_lo && !blk) begin
          if (&lo_q) begin
            lo_n    = hi_q;
            wrap_lo = 1'b1;
          end else begin
            lo_n = lo_q + 1'b1;
          end
        end
      end
      MODE_SPLIT: begin
        if (CAN_SPLIT) begin
          if (step_lo && !wr_lo) begin
            lo_n    = lo_q + 1'b1;
            wrap_lo = &lo_q;
          end
          if (step_hi && !wr_hi) begin
            hi_n    = hi_q + 1'b1;
            wrap_hi = &hi_q;
          end
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        run_en,
  input  logic [1:0]        gate_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [1:0]        ovf_flag
);
  logic [BYTE_W-1:0] cfg_q;
  logic [N_TMR-1:0]  gsync_n, run_ok, ovf_q, set_v;
  logic [BYTE_W-1:0] t0_lo_q, t0_hi_q, t1_lo_q, t1_hi_q;
  logic              t0_wrap_lo, t0_wrap_hi, t1_wrap_lo, t1_wrap_hi;
  tmode_e            t0_mode, t1_mode;
  logic              split0;

  assign t0_mode = tmode_e'(cfg_q[1:0]);
  assign t1_mode = tmode_e'(cfg_q[5:4]);
  assign split0  = (t0_mode == MODE_SPLIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cfg_q <= '0;
    else if (bus_we && bus_addr == A_CFG) cfg_q <= bus_wdata & CFG_MASK;
  end

  dtmr_gate_sync #(.N(N_TMR), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (gate_n),
    .sync_n  (gsync_n)
  );

  assign run_ok[0] = run_en[0] & (~cfg_q[3] | ~gsync_n[0]);
  assign run_ok[1] = run_en[1] & (~cfg_q[7] | ~gsync_n[1]);

  dtmr_chan #(.CAN_SPLIT(1'b1)) u_t0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (t0_mode),
    .step_lo (tick & run_ok[0]),
    .step_hi (tick & run_en[1]),
    .wr_lo   (bus_we && bus_addr == A_T0L),
    .wr_hi   (bus_we && bus_addr == A_T0H),
    .wdata   (bus_wdata),
    .lo_q    (t0_lo_q),
    .hi_q    (t0_hi_q),
    .wrap_lo (t0_wrap_lo),
    .wrap_hi (t0_wrap_hi)
  );

  dtmr_chan #(.CAN_SPLIT(1'b0)) u_t1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (t1_mode),
    .step_lo (tick & run_ok[1]),
    .step_hi (1'b0),
    .wr_lo   (bus_we && bus_addr == A_T1L),
    .wr_hi   (bus_we && bus_addr == A_T1H),
    .wdata   (bus_wdata),
    .lo_q    (t1_lo_q),
    .hi_q    (t1_hi_q),
    .wrap_lo (t1_wrap_lo),
    .wrap_hi (t1_wrap_hi)
  );

  assign set_v[0] = t0_wrap_lo;
  assign set_v[1] = split0 ? t0_wrap_hi : (t1_wrap_lo | t1_wrap_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf_q <= '0;
    else if (bus_we && bus_addr == A_FLAG)
      ovf_q <= (ovf_q & bus_wdata[N_TMR-1:0]) | set_v;
    else
      ovf_q <= ovf_q | set_v;
  end

  assign ovf_flag = ovf_q;

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = cfg_q;
      A_T0L:   bus_rdata = t0_lo_q;
      A_T0H:   bus_rdata = t0_hi_q;
      A_T1L:   bus_rdata = t1_lo_q;
      A_T1H:   bus_rdata = t1_hi_q;
      A_FLAG:  bus_rdata = {{(BYTE_W-N_TMR){1'b0}}, ovf_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dtmr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [2:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [1:0] ovf_flag,
  input logic [7:0] cfg_q,
  input logic [7:0] t0_lo,
  input logic [7:0] t0_hi,
  input logic [7:0] t1_lo,
  input logic [7:0] t1_hi
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CFG) |-> (!bus_rdata[6] && !bus_rdata[2]));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bus_we) |=> ($stable(t0_lo) && $stable(t0_hi) && $stable(t1_lo) && $stable(t1_hi)));

  p_t1_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[5:4] == 2'b11 && !(bus_we && (bus_addr == A_T1L || bus_addr == A_T1H)))
    |=> ($stable(t1_lo) && $stable(t1_hi)));

  p_reload_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'b10 && !(bus_we && bus_addr == A_T0H)) |=> $stable(t0_hi));

  p_flag0_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag[0] && !(bus_we && bus_addr == A_FLAG)) |=> ovf_flag[0]);

  p_flag1_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag[1] && !(bus_we && bus_addr == A_FLAG)) |=> ovf_flag[1]);

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_T0L) |=> (t0_lo == $past(bus_wdata)));
endmodule

bind dual_timer dual_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ovf_flag  (ovf_flag),
  .cfg_q     (cfg_q),
  .t0_lo     (t0_lo_q),
  .t0_hi     (t0_hi_q),
  .t1_lo     (t1_lo_q),
  .t1_hi     (t1_hi_q)
);

// File: tb/sim_dual_timer.sv
module sim_dual_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] run_en = 2'b00;
  logic [1:0] gate_n = 2'b11;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] ovf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en), .gate_n(gate_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic steps(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reg reset", d, 0);
    end
    chk("R1 flags reset", ovf_flag, 0);
  endtask

  task automatic t_cfg;
    logic [7:0] d;
    wr(3'd0, 8'hFF);
    rd(3'd0, d);
    chk("R2 reserved bits read 0", d, 8'hBB);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_mode13;
    logic [7:0] d;
    wr(3'd0, 8'h00); run_en = 2'b01;
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    steps(1);
    rd(3'd1, d); chk("R3 13-bit low step", d, 8'hFF);
    chk("R3 no flag before wrap", ovf_flag[0], 0);
    steps(1);
    rd(3'd1, d); chk("R3 low bits 7:5 kept", d, 8'hE0);
    rd(3'd2, d); chk("R3 high wraps", d, 8'h00);
    chk("R9 flag0 set on wrap", ovf_flag[0], 1);
    steps(2);
    chk("R9 flag0 sticky", ovf_flag[0], 1);
    wr(3'd5, 8'h00);
    chk("R9 flag0 cleared", ovf_flag[0], 0);
    wr(3'd5, 8'h03);
    chk("R9 writing 1 no effect", ovf_flag, 0);
    run_en = 2'b00;
  endtask

  task automatic t_mode16;
    logic [7:0] d;
    wr(3'd0, 8'h01); run_en = 2'b01;
    wr(3'd1, 8'hFF); wr(3'd2, 8'h12);
    steps(1);
    rd(3'd1, d); chk("R4 carry low", d, 8'h00);
    rd(3'd2, d); chk("R4 carry high", d, 8'h13);
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    steps(2);
    rd(3'd1, d); chk("R4 wrap low", d, 8'h00);
    rd(3'd2, d); chk("R4 wrap high", d, 8'h00);
    chk("R4 flag0 on wrap", ovf_flag[0], 1);
    wr(3'd5, 8'h00); run_en = 2'b00;
  endtask

  task automatic t_reload;
    logic [7:0] d;
    wr(3'd0, 8'h02); run_en = 2'b01;
    wr(3'd1, 8'hFE); wr(3'd2, 8'hF0);
    steps(2);
    rd(3'd1, d); chk("R5 reload value", d, 8'hF0);
    rd(3'd2, d); chk("R5 high unchanged", d, 8'hF0);
    chk("R5 flag0 on reload", ovf_flag[0], 1);
    steps(3);
    rd(3'd1, d); chk("R5 counts after reload", d, 8'hF3);
    wr(3'd5, 8'h00); run_en = 2'b00;
  endtask

  task automatic t_gate;
    logic [7:0] d;
    wr(3'd0, 8'h09); run_en = 2'b01; gate_n = 2'b11;
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    steps(5);
    rd(3'd1, d); chk("R8 gate inactive holds", d, 8'h00);
    gate_n = 2'b10;
    repeat (3) @(negedge clk);
    steps(4);
    rd(3'd1, d); chk("R8 gate active counts", d, 8'h04);
    run_en = 2'b00;
    steps(3);
    rd(3'd1, d); chk("R8 run off holds", d, 8'h04);
    run_en = 2'b01;
    repeat (3) @(negedge clk);
    rd(3'd1, d); chk("R8 no tick holds", d, 8'h04);
    gate_n = 2'b11; run_en = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    wr(3'd0, 8'h09); run_en = 2'b01; gate_n = 2'b11;
    wr(3'd1, 8'h00);
    @(negedge clk);
    tick = 1'b1; gate_n = 2'b10;
    @(negedge clk);
    rd(3'd1, d); chk("R11 edge 1 no count", d, 8'h00);
    @(negedge clk);
    rd(3'd1, d); chk("R11 edge 2 no count", d, 8'h00);
    @(negedge clk);
    rd(3'd1, d); chk("R11 edge 3 counts", d, 8'h01);
    tick = 1'b0; gate_n = 2'b11; run_en = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_split;
    logic [7:0] d;
    wr(3'd0, 8'h03); wr(3'd5, 8'h00);
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    run_en = 2'b01;
    steps(2);
    rd(3'd1, d); chk("R6 split low wraps", d, 8'h00);
    rd(3'd2, d); chk("R6 split high idle", d, 8'hFF);
    chk("R6 low sets flag0 only", ovf_flag, 2'b01);
    run_en = 2'b10;
    steps(1);
    rd(3'd2, d); chk("R6 split high wraps", d, 8'h00);
    rd(3'd1, d); chk("R6 split low idle", d, 8'h00);
    chk("R6 high sets flag1", ovf_flag, 2'b11);
    wr(3'd5, 8'h00); run_en = 2'b00;
  endtask

  task automatic t_t1_hold;
    logic [7:0] d;
    wr(3'd0, 8'h30); wr(3'd3, 8'h55); wr(3'd4, 8'h66);
    run_en = 2'b10;
    steps(5);
    rd(3'd3, d); chk("R7 T1 low held", d, 8'h55);
    rd(3'd4, d); chk("R7 T1 high held", d, 8'h66);
    wr(3'd0, 8'h10);
    steps(3);
    rd(3'd3, d); chk("R7 T1 resumes in 16-bit", d, 8'h58);
    run_en = 2'b00;
  endtask

  task automatic t_t1_nosplitflag;
    logic [7:0] d;
    wr(3'd0, 8'h13); wr(3'd5, 8'h00);
    wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd2, 8'h00);
    run_en = 2'b10;
    steps(1);
    rd(3'd3, d); chk("R12 T1 still counts", d, 8'h00);
    rd(3'd2, d); chk("R12 T0 high counts", d, 8'h01);
    chk("R12 T1 wrap sets no flag", ovf_flag, 2'b00);
    run_en = 2'b00;
  endtask

  task automatic t_prio;
    logic [7:0] d;
    wr(3'd0, 8'h01); run_en = 2'b01;
    wr(3'd1, 8'h10); wr(3'd2, 8'h00);
    @(negedge clk);
    tick = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h40; bus_we = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_we = 1'b0;
    rd(3'd1, d); chk("R10 write beats step", d, 8'h40);
    rd(3'd2, d); chk("R10 high not stepped", d, 8'h00);
    run_en = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_mode13();
    t_mode16();
    t_reload();
    t_gate();
    t_sync();
    t_split();
    t_t1_hold();
    t_t1_nosplitflag();
    t_prio();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule